// File: doc/BRIEF.md
# Indirect Ethernet Control/Status Register Bank

This block is the register bank of an Ethernet controller, reached by the host through two ports. A write to the address port picks a register index. Every later data-port access reads or writes that register until the index is written again. The bank holds:

- the main command/status register;
- the two halves of the initialization-block address;
- a three-bit bus-control register;
- a 64-bit multicast filter held in four words;
- a mode word whose top bit turns on promiscuous reception.

The command/status register mixes bits of several kinds. Command bits are set by writing 1. The interrupt enable is plain read/write. Event flags are set by the rest of the controller and cleared by the host writing 1. Run bits and summary bits are read-only. A STOP command puts the bank back into a quiet state and clears the bus-control register. The bank drives a maskable interrupt line and one-cycle command pulses (init, start, stop, transmit demand) toward the rest of the controller.

Top module: `eth_csr_bank`

## Requirements
- R1: `host_wr` with `host_sel`=1 loads the low IDX_W bits of `host_wdata` as the register index. The address port reads back that index with zeros above it. With `host_sel`=0, reads (combinational) and writes go to the register that the index selects.
- R2: In the status register (index 0), bits 0 INIT, 1 STRT and 3 TDMD are set by writing 1, and writing 0 leaves them alone. Bit 6 INEA takes the written value. Setting INIT or STRT clears bit 2 STOP. Setting STRT also sets the read-only bits 4 TXON and 5 RXON.
- R3: The event inputs set flag bits 8 IDON, 9 TINT, 10 RINT, 11 MERR, 12 MISS, 13 CERR and 14 BABL. Writing 1 to a flag clears it, and writing 0 has no effect. If an event and a clear of the same bit arrive in the same cycle, the bit stays set.
- R4: Bit 15 ERR reads as the OR of MERR, MISS, CERR and BABL. Bit 7 INTR reads as the OR of all seven flags. Writes to ERR, INTR, TXON and RXON have no effect.
- R5: `irq` is high exactly when INTR and INEA are both set.
- R6: Writing a status value with bit 2 set takes priority over every other bit of that write and over events in the same cycle. The register then reads exactly 0x0004, and the bus-control register reads 0.
- R7: TDMD reads 1 for one cycle after it is written and then returns to 0. `tx_demand` is high for exactly that cycle.
- R8: `init_pulse`, `start_pulse` and `stop_pulse` are high for the single cycle after a status write that sets INIT, STRT or STOP respectively. When STOP is part of the write, only `stop_pulse` fires.
- R9: Index 3 holds three bus-control bits, and its upper bits read 0. `bus_ctl` shows the register, and `byte_swap` is its bit 2.
- R10: Indices 8 to 11 hold the multicast filter, with index 8 in the low word of `mc_filter`. Index 15 is the mode word, and its bit 15 drives `promisc`.
- R11: Indices 1 and 2 are full 16-bit words that drive `iblk_addr`, with index 2 as the upper half.
- R12: After reset the status register reads 0x0004 and every other register and the index read 0. All outputs other than `host_rdata` are low.
- R13: Data-port writes to an unmapped index (4 to 7, 12 to 14) change nothing, and reads from those indices return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | 1 selects the address port, 0 the data port |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data of the selected port |
| ev_init_done | input | 1 | Initialization finished event |
| ev_tx_done | input | 1 | Transmit finished event |
| ev_rx_done | input | 1 | Receive finished event |
| ev_mem_err | input | 1 | Memory access error event |
| ev_missed | input | 1 | Missed frame event |
| ev_carrier | input | 1 | Carrier error event |
| ev_babble | input | 1 | Transmit babble event |
| irq | output | 1 | Interrupt request |
| init_pulse | output | 1 | One-cycle init command |
| start_pulse | output | 1 | One-cycle start command |
| stop_pulse | output | 1 | One-cycle stop command |
| tx_demand | output | 1 | One-cycle transmit demand |
| iblk_addr | output | 32 | Initialization-block address |
| bus_ctl | output | 3 | Bus-control bits |
| byte_swap | output | 1 | Big-endian byte order selected |
| promisc | output | 1 | Promiscuous reception enabled |
| mc_filter | output | 64 | Multicast filter |

## Verification
The hardest states to reach are the same-cycle collisions. In one, an event input and a host write-one-to-clear hit the same flag. In the other, a STOP write lands together with an event and with other command bits set. The bench reaches both by raising the event input on the same falling edge that presents the data-port write, so both are sampled at one rising edge. Every flag is also swept, with the interrupt enable both off and on, to separate the error summary from the interrupt summary.

// File: rtl/eth_csr_pkg.sv
package eth_csr_pkg;
   // status register bit positions (host-visible layout)
   localparam int B_INIT  = 0;
   localparam int B_STRT  = 1;
   localparam int B_STOP  = 2;
   localparam int B_TDMD  = 3;
   localparam int B_TXON  = 4;
   localparam int B_RXON  = 5;
   localparam int B_INEA  = 6;
   localparam int B_INTR  = 7;
   localparam int B_FLAG0 = 8;
   localparam int B_ERR   = 15;

   // event flags, offset from B_FLAG0
   localparam int NFLAG   = 7;
   localparam int F_IDON  = 0;
   localparam int F_TINT  = 1;
   localparam int F_RINT  = 2;
   localparam int F_MERR  = 3;
   localparam int F_MISS  = 4;
   localparam int F_CERR  = 5;
   localparam int F_BABL  = 6;

   // register indices
   localparam int IX_STATUS  = 0;
   localparam int IX_IBLK_LO = 1;
   localparam int IX_IBLK_HI = 2;
   localparam int IX_BUSCTL  = 3;
   localparam int IX_MCAST0  = 8;
   localparam int IX_MODE    = 15;

   localparam int MODE_PROMISC = 15;
   localparam int BCTL_SWAP    = 2;
endpackage

// File: rtl/eth_csr_status.sv
module eth_csr_status
   import eth_csr_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic [NFLAG-1:0]  event_in,
   output logic [DATA_W-1:0] status,
   output logic              stop_wr,
   output logic              init_p,
   output logic              strt_p,
   output logic              stop_p,
   output logic              tdmd_p
);
   logic             init_q, strt_q, stop_q, tdmd_q, txon_q, rxon_q, inea_q;
   logic [NFLAG-1:0] flag_q;
   logic             err_sum, intr_sum;
   logic             unused_wbits;

   assign unused_wbits = ^{wdata[B_ERR], wdata[B_INTR], wdata[B_RXON], wdata[B_TXON]};
   assign stop_wr      = wr_en & wdata[B_STOP];

   // event flags: stop clears, event beats host clear
   for (genvar f = 0; f < NFLAG; f++) begin : g_flag
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                              bit_q <= 1'b0;
         else if (stop_wr)                        bit_q <= 1'b0;
         else if (event_in[f])                    bit_q <= 1'b1;
         else if (wr_en && wdata[B_FLAG0 + f])    bit_q <= 1'b0;
      end
      assign flag_q[f] = bit_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_q <= 1'b0;
         strt_q <= 1'b0;
         stop_q <= 1'b1;
         tdmd_q <= 1'b0;
         txon_q <= 1'b0;
         rxon_q <= 1'b0;
         inea_q <= 1'b0;
         init_p <= 1'b0;
         strt_p <= 1'b0;
         stop_p <= 1'b0;
      end else begin
         tdmd_q <= 1'b0;
         init_p <= 1'b0;
         strt_p <= 1'b0;
         stop_p <= 1'b0;
         if (stop_wr) begin
            stop_q <= 1'b1;
            init_q <= 1'b0;
            strt_q <= 1'b0;
            txon_q <= 1'b0;
            rxon_q <= 1'b0;
            inea_q <= 1'b0;
            stop_p <= 1'b1;
         end else if (wr_en) begin
            inea_q <= wdata[B_INEA];
            if (wdata[B_INIT]) begin
               init_q <= 1'b1;
               stop_q <= 1'b0;
               init_p <= 1'b1;
            end
            if (wdata[B_STRT]) begin
               strt_q <= 1'b1;
               txon_q <= 1'b1;
               rxon_q <= 1'b1;
               stop_q <= 1'b0;
               strt_p <= 1'b1;
            end
            if (wdata[B_TDMD]) tdmd_q <= 1'b1;
         end
      end
   end

   assign err_sum  = flag_q[F_MERR] | flag_q[F_MISS] | flag_q[F_CERR] | flag_q[F_BABL];
   assign intr_sum = |flag_q;
   assign tdmd_p   = tdmd_q;

   always_comb begin
      status                          = '0;
      status[B_INIT]                  = init_q;
      status[B_STRT]                  = strt_q;
      status[B_STOP]                  = stop_q;
      status[B_TDMD]                  = tdmd_q;
      status[B_TXON]                  = txon_q;
      status[B_RXON]                  = rxon_q;
      status[B_INEA]                  = inea_q;
      status[B_INTR]                  = intr_sum;
      status[B_FLAG0 +: NFLAG]        = flag_q;
      status[B_ERR]                   = err_sum;
   end
endmodule

// File: rtl/eth_csr_store.sv
module eth_csr_store
   import eth_csr_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int IDX_W    = 4,
   parameter int MC_WORDS = 4,
   parameter int BCTL_W   = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           idx,
   input  logic [DATA_W-1:0]          wdata,
   input  logic                       bctl_clr,
   output logic [DATA_W-1:0]          rd_data,
   output logic [2*DATA_W-1:0]        iblk_addr,
   output logic [BCTL_W-1:0]          bctl,
   output logic [DATA_W-1:0]          mode,
   output logic [MC_WORDS*DATA_W-1:0] mc_flat
);
   localparam logic [IDX_W-1:0] I_LO   = IDX_W'(IX_IBLK_LO);
   localparam logic [IDX_W-1:0] I_HI   = IDX_W'(IX_IBLK_HI);
   localparam logic [IDX_W-1:0] I_BCTL = IDX_W'(IX_BUSCTL);
   localparam logic [IDX_W-1:0] I_MODE = IDX_W'(IX_MODE);

   logic [DATA_W-1:0] lo_q, hi_q, mode_q;
   logic [BCTL_W-1:0] bctl_q;
   logic [DATA_W-1:0] mc_q [MC_WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         mode_q <= '0;
         bctl_q <= '0;
      end else begin
         if (wr_en && idx == I_LO)   lo_q   <= wdata;
         if (wr_en && idx == I_HI)   hi_q   <= wdata;
         if (wr_en && idx == I_MODE) mode_q <= wdata;
         if (bctl_clr)               bctl_q <= '0;
         else if (wr_en && idx == I_BCTL) bctl_q <= wdata[BCTL_W-1:0];
      end
   end

   for (genvar k = 0; k < MC_WORDS; k++) begin : g_mc
      localparam logic [IDX_W-1:0] I_MC = IDX_W'(IX_MCAST0 + k);
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                   word_q <= '0;
         else if (wr_en && idx == I_MC) word_q <= wdata;
      end
      assign mc_q[k]                        = word_q;
      assign mc_flat[k*DATA_W +: DATA_W]    = word_q;
   end

   always_comb begin
      rd_data = '0;
      if (idx == I_LO)   rd_data = lo_q;
      if (idx == I_HI)   rd_data = hi_q;
      if (idx == I_MODE) rd_data = mode_q;
      if (idx == I_BCTL) rd_data = DATA_W'(bctl_q);
      for (int k = 0; k < MC_WORDS; k++)
         if (idx == IDX_W'(IX_MCAST0 + k)) rd_data = mc_q[k];
   end

   assign iblk_addr = {hi_q, lo_q};
   assign bctl      = bctl_q;
   assign mode      = mode_q;
endmodule

// File: rtl/eth_csr_bank.sv
module eth_csr_bank
   import eth_csr_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int IDX_W    = 4,
   parameter int MC_WORDS = 4,
   parameter int BCTL_W   = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       host_sel,
   input  logic                       host_wr,
   input  logic [DATA_W-1:0]          host_wdata,
   output logic [DATA_W-1:0]          host_rdata,
   input  logic                       ev_init_done,
   input  logic                       ev_tx_done,
   input  logic                       ev_rx_done,
   input  logic                       ev_mem_err,
   input  logic                       ev_missed,
   input  logic                       ev_carrier,
   input  logic                       ev_babble,
   output logic                       irq,
   output logic                       init_pulse,
   output logic                       start_pulse,
   output logic                       stop_pulse,
   output logic                       tx_demand,
   output logic [2*DATA_W-1:0]        iblk_addr,
   output logic [BCTL_W-1:0]          bus_ctl,
   output logic                       byte_swap,
   output logic                       promisc,
   output logic [MC_WORDS*DATA_W-1:0] mc_filter
);
   localparam logic [IDX_W-1:0] I_STAT = IDX_W'(IX_STATUS);

   // elaboration-time parameter checks
   if (DATA_W != 16) begin : g_bad_data_w
      $error("eth_csr_bank: DATA_W must be 16");
   end
   if (IDX_W < 4 || IDX_W > DATA_W) begin : g_bad_idx_w
      $error("eth_csr_bank: IDX_W must be 4..DATA_W");
   end
   if (IX_MCAST0 + MC_WORDS > IX_MODE) begin : g_bad_mc
      $error("eth_csr_bank: multicast words overlap the mode index");
   end
   if (BCTL_W < 3 || BCTL_W > DATA_W) begin : g_bad_bctl
      $error("eth_csr_bank: BCTL_W must hold the byte-swap bit");
   end

   logic [IDX_W-1:0]  idx_q;
   logic              data_wr, stat_wr, stop_wr;
   logic [DATA_W-1:0] status_w, store_rd, mode_w;
   logic [NFLAG-1:0]  ev_vec;

   assign data_wr = host_wr & ~host_sel;
   assign stat_wr = data_wr & (idx_q == I_STAT);

   always_ff @(posedge clk) begin
      if (!rst_n)                 idx_q <= '0;
      else if (host_wr && host_sel) idx_q <= host_wdata[IDX_W-1:0];
   end

   always_comb begin
      ev_vec         = '0;
      ev_vec[F_IDON] = ev_init_done;
      ev_vec[F_TINT] = ev_tx_done;
      ev_vec[F_RINT] = ev_rx_done;
      ev_vec[F_MERR] = ev_mem_err;
      ev_vec[F_MISS] = ev_missed;
      ev_vec[F_CERR] = ev_carrier;
      ev_vec[F_BABL] = ev_babble;
   end

   eth_csr_status #(.DATA_W(DATA_W)) i_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (stat_wr),
      .wdata    (host_wdata),
      .event_in (ev_vec),
      .status   (status_w),
      .stop_wr  (stop_wr),
      .init_p   (init_pulse),
      .strt_p   (start_pulse),
      .stop_p   (stop_pulse),
      .tdmd_p   (tx_demand)
   );

   eth_csr_store #(
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .MC_WORDS (MC_WORDS),
      .BCTL_W   (BCTL_W)
   ) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (data_wr),
      .idx       (idx_q),
      .wdata     (host_wdata),
      .bctl_clr  (stop_wr),
      .rd_data   (store_rd),
      .iblk_addr (iblk_addr),
      .bctl      (bus_ctl),
      .mode      (mode_w),
      .mc_flat   (mc_filter)
   );

   always_comb begin
      if (host_sel)              host_rdata = DATA_W'(idx_q);
      else if (idx_q == I_STAT)  host_rdata = status_w;
      else                       host_rdata = store_rd;
   end

   assign irq       = status_w[B_INTR] & status_w[B_INEA];
   assign byte_swap = bus_ctl[BCTL_SWAP];
   assign promisc   = mode_w[MODE_PROMISC];
endmodule

// File: rtl/eth_csr_bank_chk.sv
module eth_csr_bank_chk #(
   parameter int IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_sel,
   input logic             host_wr,
   input logic [IDX_W-1:0] wr_idx_bits,
   input logic             wr_stop_bit,
   input logic             wr_strt_bit,
   input logic             ev_tx_done,
   input logic             irq,
   input logic             start_pulse,
   input logic             stop_pulse,
   input logic             tx_demand,
   input logic             byte_swap,
   input logic [15:0]      status,
   input logic [IDX_W-1:0] cur_idx
);
   logic stat_wr;
   assign stat_wr = host_wr && !host_sel && (cur_idx == '0);

   AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_sel) |=> (cur_idx == $past(wr_idx_bits)));                 // R1

   AST_TDMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_demand |=> !tx_demand);                                                    // R7

   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && wr_stop_bit) |=> (stop_pulse && !byte_swap && !irq && status == 16'h0004)); // R6

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && wr_strt_bit && !wr_stop_bit) |=> (start_pulse && status[4] && status[5])); // R8

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_tx_done && !(stat_wr && wr_stop_bit)) |=> (status[9] && status[7]));      // R3

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> status[6]);                                                    // R5
endmodule

bind eth_csr_bank eth_csr_bank_chk #(.IDX_W(IDX_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_sel    (host_sel),
   .host_wr     (host_wr),
   .wr_idx_bits (host_wdata[IDX_W-1:0]),
   .wr_stop_bit (host_wdata[2]),
   .wr_strt_bit (host_wdata[1]),
   .ev_tx_done  (ev_tx_done),
   .irq         (irq),
   .start_pulse (start_pulse),
   .stop_pulse  (stop_pulse),
   .tx_demand   (tx_demand),
   .byte_swap   (byte_swap),
   .status      (status_w),
   .cur_idx     (idx_q)
);

// File: tb/test_eth_csr_bank.sv
`timescale 1ns/1ps
module test_eth_csr_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_sel = 1'b0;
   logic        host_wr = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic [6:0]  ev = '0;   // 0 idon,1 tint,2 rint,3 merr,4 miss,5 cerr,6 babl
   logic        irq, init_pulse, start_pulse, stop_pulse, tx_demand;
   logic [31:0] iblk_addr;
   logic [2:0]  bus_ctl;
   logic        byte_swap, promisc;
   logic [63:0] mc_filter;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   eth_csr_bank i_eth_csr_bank (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .ev_init_done(ev[0]), .ev_tx_done(ev[1]), .ev_rx_done(ev[2]),
      .ev_mem_err(ev[3]), .ev_missed(ev[4]), .ev_carrier(ev[5]), .ev_babble(ev[6]),
      .irq(irq), .init_pulse(init_pulse), .start_pulse(start_pulse),
      .stop_pulse(stop_pulse), .tx_demand(tx_demand), .iblk_addr(iblk_addr),
      .bus_ctl(bus_ctl), .byte_swap(byte_swap), .promisc(promisc),
      .mc_filter(mc_filter)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [15:0] d);
      @(negedge clk);
      host_sel = sel; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd_data(output logic [15:0] v);
      host_sel = 1'b0; #1; v = host_rdata;
   endtask

   task automatic chk_stat(input string req, input logic [15:0] exp);
      logic [15:0] v;
      rd_data(v);
      chk(req, 64'(v), 64'(exp));
   endtask

   task automatic pulse_ev(input int f);
      @(negedge clk); ev[f] = 1'b1;
      @(negedge clk); ev = '0;
   endtask

   function automatic logic [15:0] pat(input int i);
      return 16'hA5C7 ^ (16'(i) * 16'h1111);
   endfunction

   function automatic logic [15:0] exp_store(input int i);
      if (i == 1 || i == 2 || i == 15 || (i >= 8 && i <= 11)) return pat(i);
      if (i == 3) return {13'd0, pat(i)[2:0]};
      return 16'h0000;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [15:0] v;
      logic [15:0] base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk_stat("R12 status after reset", 16'h0004);
      host_sel = 1'b1; #1;
      chk("R12 index after reset", 64'(host_rdata), 64'h0);
      chk("R12 outputs after reset",
          {irq, init_pulse, start_pulse, stop_pulse, tx_demand, byte_swap, promisc, bus_ctl},
          '0);
      chk("R12 iblk/mc after reset", {iblk_addr, mc_filter[31:0]}, '0);

      // R1 R9 R10 R11 R13 sweep over every non-status index
      for (int i = 1; i < 16; i++) begin
         wr(1'b1, 16'h1230 | 16'(i));
         host_sel = 1'b1; #1;
         chk("R1 address port readback", 64'(host_rdata), 64'(i));
         wr(1'b0, pat(i));
         rd_data(v);
         chk((i >= 4 && i <= 7) || (i >= 12 && i <= 14) ? "R13 unmapped read" : "R1 data readback",
             64'(v), 64'(exp_store(i)));
      end
      chk("R11 iblk_addr", 64'(iblk_addr), 64'({pat(2), pat(1)}));
      chk("R9 bus_ctl", 64'(bus_ctl), 64'(pat(3)[2:0]));
      chk("R9 byte_swap", 64'(byte_swap), 64'(pat(3)[2]));
      chk("R10 mc_filter", mc_filter, {pat(11), pat(10), pat(9), pat(8)});
      chk("R10 promisc low", 64'(promisc), 64'(pat(15)[15]));
      wr(1'b0, 16'h8000);
      chk("R10 promisc set", 64'(promisc), 64'h1);
      for (int i = 1; i < 16; i++) begin
         wr(1'b1, 16'(i));
         rd_data(v);
         if (i != 15)
            chk("R13 no side effects of sweep", 64'(v), 64'(exp_store(i)));
      end

      // R6 STOP with INIT: only STOP reads back, bus control cleared
      wr(1'b1, 16'h0000);
      wr(1'b0, 16'h0005);
      chk_stat("R6 init|stop reads stop", 16'h0004);
      chk("R6 bus_ctl cleared", 64'({byte_swap, bus_ctl}), 64'h0);
      chk("R8 stop pulse only", 64'({init_pulse, start_pulse, stop_pulse}), 64'b001);
      @(negedge clk);
      chk("R8 stop pulse one cycle", 64'(stop_pulse), 64'h0);

      // R2 R8 command bits
      wr(1'b0, 16'h0001);
      chk_stat("R2 init set clears stop", 16'h0001);
      chk("R8 init pulse", 64'(init_pulse), 64'h1);
      wr(1'b0, 16'h0000);
      chk_stat("R2 writing 0 keeps init", 16'h0001);
      chk("R8 init pulse gone", 64'(init_pulse), 64'h0);
      wr(1'b0, 16'h0002);
      chk_stat("R2 strt sets txon rxon", 16'h0033);
      chk("R8 start pulse", 64'(start_pulse), 64'h1);
      wr(1'b0, 16'h0040);
      chk_stat("R2 inea written 1", 16'h0073);
      wr(1'b0, 16'h0000);
      chk_stat("R2 inea written 0", 16'h0033);

      // R7 transmit demand
      wr(1'b0, 16'h0008);
      chk_stat("R7 tdmd visible", 16'h003B);
      chk("R7 tx_demand high", 64'(tx_demand), 64'h1);
      @(negedge clk);
      chk_stat("R7 tdmd self clears", 16'h0033);
      chk("R7 tx_demand low", 64'(tx_demand), 64'h0);

      // R3 R4 R5 sweep over every flag with INEA off and on
      for (int f = 0; f < 7; f++) begin
         for (int ie = 0; ie < 2; ie++) begin
            base = 16'h0033 | (ie != 0 ? 16'h0040 : 16'h0000);
            wr(1'b0, base & 16'h0040);
            pulse_ev(f);
            chk_stat("R3 R4 flag set by event",
                     base | (16'h0100 << f) | 16'h0080 | (f >= 3 ? 16'h8000 : 16'h0000));
            chk("R5 irq follows INEA", 64'(irq), 64'(ie));
            wr(1'b0, 16'h8090 | (base & 16'h0040));
            chk_stat("R4 summary/readonly writes ignored",
                     base | (16'h0100 << f) | 16'h0080 | (f >= 3 ? 16'h8000 : 16'h0000));
            wr(1'b0, (16'h0100 << f) | (base & 16'h0040));
            chk_stat("R3 write one clears flag", base);
            chk("R5 irq low after clear", 64'(irq), 64'h0);
         end
      end

      // R3 collision: event beats clear
      @(negedge clk);
      ev[1] = 1'b1; host_sel = 1'b0; host_wdata = 16'h0200; host_wr = 1'b1;
      @(negedge clk);
      ev = '0; host_wr = 1'b0;
      chk_stat("R3 event wins over clear", 16'h02B3);
      wr(1'b0, 16'h0200);
      chk_stat("R3 clear after collision", 16'h0033);

      // R6 STOP beats same-cycle event
      wr(1'b1, 16'h0003);
      wr(1'b0, 16'h0004);
      wr(1'b1, 16'h0000);
      @(negedge clk);
      ev[6] = 1'b1; host_sel = 1'b0; host_wdata = 16'h0047; host_wr = 1'b1;
      @(negedge clk);
      ev = '0; host_wr = 1'b0;
      chk_stat("R6 stop beats event and commands", 16'h0004);
      chk("R6 irq low after stop", 64'(irq), 64'h0);
      chk("R8 only stop pulse", 64'({init_pulse, start_pulse, stop_pulse}), 64'b001);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule